// File: doc/BRIEF.md
# Interrupt Coalescing and Status Unit

This unit gathers event pulses from a network controller's descriptor queues and FIFOs into a sticky raw cause register. An enable register masks those causes into a status view, and the OR of that view drives one interrupt line. Software reads the raw register and writes the same value back to acknowledge what it has seen. Bits that were not written stay set.

The two descriptor-arrival sources are coalesced so the host is not interrupted on every descriptor. One source is receive completions entering the busy queue; the other is transmit completions entering the reclaim queue. Each direction has its own pending counter. A count cause fires when the number of uncounted descriptors reaches a programmed threshold. If the threshold is not reached in time, a separate timeout cause fires once a programmed number of cycles have passed since the first uncounted descriptor arrived. The queue logic outside this unit supplies one-cycle increment pulses.

Configuration uses a plain word-addressed port with no handshake. A write takes effect on the clock edge where `cfg_wr` is high. A read returns, without a clock edge, the register that `cfg_addr` selects. Event inputs are single-cycle pulses. There is no back-pressure: the unit accepts a pulse in every cycle.

Top module: `irq_coalesce_unit`

## Requirements
- R1: Writing the raw cause register (address 0) clears exactly the bits written as 1. All other bits keep their value.
- R2: The status register (address 2) reads raw AND enable, with enable at address 1. `irq` is high exactly when that status is non-zero.
- R3: When a source event arrives in the same cycle as a write that clears its raw bit, the event wins and the bit stays set.
- R4: The raw bits are laid out as follows.
  - `flag_evt[i]` sets raw bit i, for i = 0..15.
  - `fifo_err` sets raw bit 30.
  - Raw bits 16, 18, 20..27 and 31 always read 0.
- R5: The threshold register (address 3) holds the receive count in bits 15:0 and the transmit count in bits 31:16.
  - Raw bit 17 (receive) or bit 19 (transmit) sets on the edge that accepts the descriptor which brings that direction's pending count up to its threshold.
  - That edge also clears the pending count.
- R6: A threshold of 0 or 1 sets the count cause on every descriptor pulse.
- R7: Timeout cause, raw bit 28 for receive and bit 29 for transmit, with the timeout value held at address 4 (receive) or address 5 (transmit).
  - The bit sets exactly that many clock edges after the edge that accepted the first uncounted descriptor, unless a count cause fires earlier.
  - A count cause clears the timer.
- R8: If the count cause and the timeout cause of one direction fall on the same edge, only the count bit is set.
- R9: A timeout value of 0 disables that direction's timeout cause.
- R10: After reset:
  - raw and enable are 0 and `irq` is low;
  - both thresholds are 1;
  - the receive timeout is 0x10000 and the transmit timeout is 0x50000.
- R11: Writes to the status address (2) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_evt | input | 16 | Queue empty/full/almost flags, one pulse per bit |
| fifo_err | input | 1 | MAC FIFO error pulse |
| rx_desc_in | input | 1 | One receive descriptor entered the busy queue |
| tx_desc_in | input | 1 | One transmit descriptor entered the reclaim queue |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| irq | output | 1 | Interrupt line |

## Verification
The embedded assertions check four things on every cycle:
- a pulsed source bit is set on the next cycle even when a clear lands on it at the same time;
- a cleared bit with no competing source reads zero;
- the interrupt line is never high while the raw register is empty;
- a direction's timer is idle whenever nothing is pending, and a count cause never shares an edge with that direction's timeout cause.

The exact edge on which a threshold or timeout fires, the enable masking seen at the ports, and the field placement in the threshold register can only be shown by the bench's directed scenarios. So can the tie between a count and a timeout, the disabled timeout, and the ignored status write. The random phase then compares every raw and interrupt value against a bench model while flag pulses, clears and enable writes overlap.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int REG_W        = 32;
  localparam int NUM_FLAGS    = 16;
  localparam int NUM_DIR      = 2;   // 0 = receive, 1 = transmit
  localparam int BIT_RX_CNT   = 17;
  localparam int BIT_TX_CNT   = 19;
  localparam int BIT_RX_TMO   = 28;
  localparam int BIT_TX_TMO   = 29;
  localparam int BIT_FIFO_ERR = 30;
  localparam int THR_FIELD_W  = 16;

  typedef enum logic [2:0] {
    A_RAW    = 3'd0,
    A_ENA    = 3'd1,
    A_STAT   = 3'd2,
    A_THR    = 3'd3,
    A_RX_TMO = 3'd4,
    A_TX_TMO = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int CNT_W = 16,
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_in,
  input  logic [CNT_W-1:0] thr,
  input  logic [TMO_W-1:0] tmo,
  output logic             cnt_evt,
  output logic             tmo_evt
);
  logic [CNT_W-1:0] pend;
  logic [TMO_W-1:0] tmr;
  logic [CNT_W:0]   pend_inc;
  logic [CNT_W:0]   thr_eff;
  logic             has_pend;

  assign has_pend = (pend != '0);
  assign thr_eff  = (thr == '0) ? (CNT_W+1)'(1) : {1'b0, thr};
  assign pend_inc = {1'b0, pend} + (CNT_W+1)'(desc_in);

  // count wins over timeout on the same edge
  assign cnt_evt = desc_in && (pend_inc >= thr_eff);
  assign tmo_evt = has_pend && (tmo != '0) && (tmr >= tmo - 1'b1) && !cnt_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      tmr  <= '0;
    end else if (cnt_evt) begin
      pend <= '0;
      tmr  <= '0;
    end else if (tmo_evt) begin
      pend <= CNT_W'(desc_in);
      tmr  <= '0;
    end else begin
      pend <= pend_inc[CNT_W-1:0];
      if (!has_pend)
        tmr <= '0;
      else if (tmr != '1)
        tmr <= tmr + 1'b1;
    end
  end

  // R7: timer is idle whenever nothing is pending
  p_idle_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (tmr == '0));

  // R5: a count event leaves nothing pending
  p_count_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt |=> (pend == '0));
endmodule

// File: rtl/irq_raw_reg.sv
module irq_raw_reg
  import irq_coal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_vec,
  input  logic             ena_we,
  input  logic [REG_W-1:0] ena_wdata,
  output logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] ena,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  logic [REG_W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      ena <= '0;
    end else begin
      raw <= (raw & ~clr_eff) | set_vec;
      if (ena_we)
        ena <= ena_wdata;
    end
  end

  assign status = raw & ena;
  assign irq    = |status;

  // R3: a pulsed source is set next cycle regardless of a clear
  p_src_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw & $past(set_vec)) == $past(set_vec)));

  // R1: cleared bits without a competing source read zero
  p_w1c_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw & $past(clr_vec & ~set_vec)) == '0));

  // R2: the line never rises without a raw cause
  p_irq_needs_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw != '0));
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit
  import irq_coal_pkg::*;
#(
  parameter int          CNT_W      = 16,  // at most 16, the threshold field width
  parameter int          TMO_W      = 32,  // at most 32
  parameter int          THR_RST    = 1,
  parameter logic [31:0] RX_TMO_RST = 32'h0001_0000,
  parameter logic [31:0] TX_TMO_RST = 32'h0005_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] flag_evt,
  input  logic        fifo_err,
  input  logic        rx_desc_in,
  input  logic        tx_desc_in,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        irq
);
  localparam int CNT_BIT [NUM_DIR] = '{BIT_RX_CNT, BIT_TX_CNT};
  localparam int TMO_BIT [NUM_DIR] = '{BIT_RX_TMO, BIT_TX_TMO};

  logic [CNT_W-1:0] thr_q   [NUM_DIR];
  logic [TMO_W-1:0] tmo_q   [NUM_DIR];
  logic [NUM_DIR-1:0] desc_v, cnt_evt, tmo_evt;
  logic [REG_W-1:0] set_vec, raw, ena, status;

  assign desc_v = {tx_desc_in, rx_desc_in};

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q[0] <= CNT_W'(THR_RST);
      thr_q[1] <= CNT_W'(THR_RST);
      tmo_q[0] <= TMO_W'(RX_TMO_RST);
      tmo_q[1] <= TMO_W'(TX_TMO_RST);
    end else if (cfg_wr) begin
      case (cfg_addr)
        A_THR: begin
          thr_q[0] <= cfg_wdata[CNT_W-1:0];
          thr_q[1] <= cfg_wdata[THR_FIELD_W +: CNT_W];
        end
        A_RX_TMO: tmo_q[0] <= cfg_wdata[TMO_W-1:0];
        A_TX_TMO: tmo_q[1] <= cfg_wdata[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  genvar gd;
  generate
    for (gd = 0; gd < NUM_DIR; gd++) begin : g_dir
      irq_coalescer #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_coal (
        .clk     (clk),
        .rst_n   (rst_n),
        .desc_in (desc_v[gd]),
        .thr     (thr_q[gd]),
        .tmo     (tmo_q[gd]),
        .cnt_evt (cnt_evt[gd]),
        .tmo_evt (tmo_evt[gd])
      );
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    set_vec[NUM_FLAGS-1:0] = flag_evt;
    set_vec[BIT_FIFO_ERR]  = fifo_err;
    for (int d = 0; d < NUM_DIR; d++) begin
      set_vec[CNT_BIT[d]] = cnt_evt[d];
      set_vec[TMO_BIT[d]] = tmo_evt[d];
    end
  end

  irq_raw_reg u_raw (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_we    (cfg_wr && (cfg_addr == A_RAW)),
    .clr_vec   (cfg_wdata),
    .ena_we    (cfg_wr && (cfg_addr == A_ENA)),
    .ena_wdata (cfg_wdata),
    .raw       (raw),
    .ena       (ena),
    .status    (status),
    .irq       (irq)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_RAW:    cfg_rdata = raw;
      A_ENA:    cfg_rdata = ena;
      A_STAT:   cfg_rdata = status;
      A_THR: begin
        cfg_rdata[CNT_W-1:0]              = thr_q[0];
        cfg_rdata[THR_FIELD_W +: CNT_W]   = thr_q[1];
      end
      A_RX_TMO: cfg_rdata = REG_W'(tmo_q[0]);
      A_TX_TMO: cfg_rdata = REG_W'(tmo_q[1]);
      default:  cfg_rdata = '0;
    endcase
  end

  // R8: count and timeout of one direction never share an edge
  p_cnt_tmo_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_vec[BIT_RX_CNT], set_vec[BIT_RX_TMO]}) &&
    $onehot0({set_vec[BIT_TX_CNT], set_vec[BIT_TX_TMO]}));

  // R4: unused cause positions never set
  p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & 32'h8FF5_0000) == '0);
endmodule

// File: tb/sim_irq_coalesce_unit.sv
module sim_irq_coalesce_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] flag_evt = '0;
  logic        fifo_err = 1'b0;
  logic        rx_desc_in = 1'b0;
  logic        tx_desc_in = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_coalesce_unit u0 (
    .clk(clk), .rst_n(rst_n), .flag_evt(flag_evt), .fifo_err(fifo_err),
    .rx_desc_in(rx_desc_in), .tx_desc_in(tx_desc_in), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
  );

  function automatic logic [31:0] next_raw(input logic [31:0] r, input logic [31:0] clr,
                                           input logic [15:0] fl, input logic fe);
    logic [31:0] s;
    s = {1'b0, fe, 13'd0, 1'b0, fl};
    return (r & ~clr) | s;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    cfg_addr = a;
    #1;
    v = cfg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rx_pulse();
    rx_desc_in = 1'b1; tick(); rx_desc_in = 1'b0;
  endtask

  task automatic tx_pulse();
    tx_desc_in = 1'b1; tick(); tx_desc_in = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, exp_raw, exp_ena;
    void'($urandom(32'h5EED_1234));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10 reset state
    rd(3'd0, v); chk("R10 raw", v, 32'h0);
    rd(3'd1, v); chk("R10 ena", v, 32'h0);
    rd(3'd3, v); chk("R10 thr", v, 32'h0001_0001);
    rd(3'd4, v); chk("R10 rx tmo", v, 32'h0001_0000);
    rd(3'd5, v); chk("R10 tx tmo", v, 32'h0005_0000);
    chk("R10 irq", {31'd0, irq}, 32'd0);

    // R5 count coalescing, rx thr 3 (bits 15:0), tx thr 2 (bits 31:16)
    wr(3'd4, 32'd1000); wr(3'd5, 32'd1000);
    wr(3'd3, {16'd2, 16'd3});
    rx_pulse(); rx_pulse();
    rd(3'd0, v); chk("R5 rx below thr", v[17], 1'b0);
    rx_pulse();
    rd(3'd0, v); chk("R5 rx at thr", v[17], 1'b1);
    tx_pulse();
    rd(3'd0, v); chk("R5 tx below thr", v[19], 1'b0);
    tx_pulse();
    rd(3'd0, v); chk("R5 tx at thr", v[19], 1'b1);

    // R2 masking
    wr(3'd1, 32'h0002_0000);
    rd(3'd2, v); chk("R2 status", v, 32'h0002_0000);
    chk("R2 irq on", {31'd0, irq}, 32'd1);

    // R11 status write ignored
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R11 raw kept", v, 32'h000A_0000);
    rd(3'd1, v); chk("R11 ena kept", v, 32'h0002_0000);

    // R1 selective clear
    wr(3'd0, 32'h0002_0000);
    rd(3'd0, v); chk("R1 partial clear", v, 32'h0008_0000);
    chk("R2 irq off", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);

    // R7 rx timeout: 20 edges after first descriptor
    wr(3'd3, {16'd100, 16'd100});
    wr(3'd4, 32'd20);
    rx_pulse();
    repeat (19) tick();
    rd(3'd0, v); chk("R7 rx before timeout", v[28], 1'b0);
    tick();
    rd(3'd0, v); chk("R7 rx timeout edge", v[28], 1'b1);
    chk("R7 no count", v[17], 1'b0);

    // R7 tx timeout 7
    wr(3'd5, 32'd7);
    tx_pulse();
    repeat (6) tick();
    rd(3'd0, v); chk("R7 tx before timeout", v[29], 1'b0);
    tick();
    rd(3'd0, v); chk("R7 tx timeout edge", v[29], 1'b1);
    wr(3'd0, 32'hFFFF_FFFF);

    // R7 count clears timer: thr 3, tmo 20
    wr(3'd3, {16'd100, 16'd3});
    rx_pulse(); repeat (10) tick(); rx_pulse(); rx_pulse();
    rd(3'd0, v); chk("R7 count fired", v[17], 1'b1);
    repeat (30) tick();
    rd(3'd0, v); chk("R7 timer cleared by count", v[28], 1'b0);
    wr(3'd0, 32'hFFFF_FFFF);

    // R8 tie: thr 2, tmo 5; second descriptor lands on timeout edge
    wr(3'd3, {16'd100, 16'd2});
    wr(3'd4, 32'd5);
    rx_pulse(); repeat (4) tick(); rx_pulse();
    rd(3'd0, v); chk("R8 count set", v[17], 1'b1);
    chk("R8 timeout suppressed", v[28], 1'b0);
    repeat (10) tick();
    rd(3'd0, v); chk("R8 no late timeout", v[28], 1'b0);
    wr(3'd0, 32'hFFFF_FFFF);

    // R9 timeout 0 disables
    wr(3'd3, {16'd100, 16'd100});
    wr(3'd4, 32'd0);
    rx_pulse(); repeat (60) tick();
    rd(3'd0, v); chk("R9 no timeout", v, 32'h0);

    // R6 threshold 0 (tx) and 1 (rx)
    wr(3'd3, {16'd0, 16'd1});
    tx_pulse();
    rd(3'd0, v); chk("R6 tx thr0 first", v[19], 1'b1);
    wr(3'd0, 32'hFFFF_FFFF);
    tx_pulse();
    rd(3'd0, v); chk("R6 tx thr0 second", v[19], 1'b1);
    rx_pulse();
    rd(3'd0, v); chk("R6 rx thr1", v[17], 1'b1);
    wr(3'd4, 32'd1000); wr(3'd5, 32'd1000);
    wr(3'd0, 32'hFFFF_FFFF);

    // R3 source beats same-cycle clear
    flag_evt = 16'h0020; fifo_err = 1'b1;
    wr(3'd0, 32'h4000_0020);
    flag_evt = '0; fifo_err = 1'b0;
    rd(3'd0, v); chk("R3 set wins", v, 32'h4000_0020);
    wr(3'd0, 32'hFFFF_FFFF);

    // R4 R1 R2 random flags, clears and enables against a model
    exp_raw = '0; exp_ena = '0;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] fl;
      logic fe;
      logic [31:0] clr, d;
      int op;
      fl = 16'($urandom & $urandom);
      fe = ($urandom % 8) == 0;
      op = $urandom % 4;
      d = $urandom;
      clr = '0;
      flag_evt = fl; fifo_err = fe;
      if (op == 0) begin
        clr = d;
        wr(3'd0, d);
      end else if (op == 1) begin
        wr(3'd1, d);
        exp_ena = d;
      end else begin
        tick();
      end
      flag_evt = '0; fifo_err = 1'b0;
      exp_raw = next_raw(exp_raw, clr, fl, fe);
      rd(3'd0, v); chk("R4 raw model", v, exp_raw);
      rd(3'd2, v); chk("R2 status model", v, exp_raw & exp_ena);
      chk("R2 irq model", {31'd0, irq}, {31'd0, |(exp_raw & exp_ena)});
    end

    finish_run();
  end
endmodule